// File: doc/BRIEF.md
# Serial Character Compare and Replace Filter

This block sits in the byte path of a serial channel and inspects every character that passes through. Two programmable compare values are held in a small register bank, each with its own enable. A character that equals an enabled compare value raises a match event and then, depending on the action bits, is forwarded untouched, dropped from the stream, or swapped for substitute bytes. A hit on the first compare value can turn one input character into two output characters. A hit on the second compare value can only become a single substitute byte.

Bytes enter and leave through valid/ready handshakes and keep their order. The output side has one holding register and one slot for a pending second byte. While a two-byte substitution is being sent, the input is stalled for an extra cycle so that no input byte is lost. Each match produces a one-cycle strobe and sets a sticky flag. The flag stays set until the host reports that it has read the full status word.

Top module: `char_filter`

## Requirements
- R1: After reset, `out_valid`, `hit_stb` and `match_flag` are all 0, and `in_ready` is 1.
- R2: A character that matches no enabled compare value is output unchanged, and characters keep their input order.
- R3: The configuration registers are written through `cfg_we`, `cfg_addr` and `cfg_wdata`. Address 0 holds the action bits. Address 1 holds compare value 1 and address 2 holds compare value 2. Address 3 holds the first substitute byte for match 1 and address 4 holds the second. Address 5 holds the substitute byte for match 2. The action bits are: bit0 enables compare 1, bit1 enables compare 2, bit2 drops on match 1, bit3 drops on match 2, bit4 replaces match 1 with two bytes, and bit5 replaces match 2 with one byte. A match-1 character with bit2 set is dropped.
- R4: A match-1 character with bit4 set and bit2 clear is output as the address-3 byte followed by the address-4 byte. `in_ready` is low in the cycle after that character is accepted.
- R5: When bit2 and bit4 are both set, a match-1 character is dropped.
- R6: A match-2 character is dropped when bit3 is set. Otherwise, when bit5 is set, it is replaced by the single address-5 byte.
- R7: A matching character whose compare has no action bit set is output unchanged, and its match flag is still set.
- R8: `match_flag[0]` (match 1) and `match_flag[1]` (match 2) are set on the clock edge that accepts a matching character. They stay set until a cycle with `stat_rd` high clears them. A match accepted in the same cycle as `stat_rd` leaves its flag set.
- R9: `hit_stb[0]` and `hit_stb[1]` are high for exactly the one cycle after the edge that accepts a matching character.
- R10: A character that matches both enabled compare values raises both strobes and both flags, and the compare-1 action applies.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold and `in_ready` is low. No byte is lost or duplicated.
- R12: A compare whose enable bit is clear produces no strobe, no flag and no action, even when the character equals its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input character valid |
| in_data | input | 8 | Input character |
| in_ready | output | 1 | Filter can accept a character |
| out_valid | output | 1 | Output character valid |
| out_data | output | 8 | Output character |
| out_ready | input | 1 | Downstream accepts output |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| stat_rd | input | 1 | Host read of full status word, clears flags |
| hit_stb | output | 2 | Per-compare match strobe |
| match_flag | output | 2 | Per-compare sticky match flag |

## Verification
The assertions assume that `in_valid` and `out_ready` are legal handshake inputs that only change between clock edges. They also assume that configuration writes do not land in the same cycle as the character they are meant to affect. The bench drives every input at the falling edge. It writes the configuration while the stream is idle, then sends each character and waits until it has been accepted before sending the next. It raises `stat_rd` only at points where the flag value it expects is fixed by the preceding stimulus.

// File: rtl/cf_pkg.sv
package cf_pkg;
  localparam int CF_DW     = 8;
  localparam int CF_NREG   = 6;
  localparam int CF_AW     = 3;
  localparam int CF_NCMP   = 2;

  localparam logic [CF_AW-1:0] A_CTRL = 3'd0;
  localparam logic [CF_AW-1:0] A_CMP1 = 3'd1;
  localparam logic [CF_AW-1:0] A_CMP2 = 3'd2;
  localparam logic [CF_AW-1:0] A_R1LO = 3'd3;
  localparam logic [CF_AW-1:0] A_R1HI = 3'd4;
  localparam logic [CF_AW-1:0] A_R2   = 3'd5;

  // action bits; bit positions are decoded by the match logic
  typedef struct packed {
    logic sub2;
    logic dbl1;
    logic drop2;
    logic drop1;
    logic on2;
    logic on1;
  } ctrl_t;

  typedef enum logic [1:0] {
    ACT_PASS = 2'd0,
    ACT_DROP = 2'd1,
    ACT_ONE  = 2'd2,
    ACT_TWO  = 2'd3
  } act_e;
endpackage

// File: rtl/cf_cfg.sv
module cf_cfg
  import cf_pkg::*;
#(
  parameter int DW   = CF_DW,
  parameter int NREG = CF_NREG,
  parameter int AW   = CF_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] bank [NREG]
);
  logic [DW-1:0] bank_q [NREG];
  logic [DW-1:0] bank_d [NREG];
  logic [NREG-1:0] load;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_comb begin
      load[g]   = we && (addr == AW'(g));
      bank_d[g] = load[g] ? wdata : bank_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_q[g] <= '0;
      else        bank_q[g] <= bank_d[g];
    end

    assign bank[g] = bank_q[g];
  end
endmodule

// File: rtl/cf_decide.sv
module cf_decide
  import cf_pkg::*;
#(
  parameter int DW = CF_DW
) (
  input  logic [DW-1:0] ch,
  input  ctrl_t         ctrl,
  input  logic [DW-1:0] cmp1,
  input  logic [DW-1:0] cmp2,
  input  logic [DW-1:0] r1lo,
  input  logic [DW-1:0] r1hi,
  input  logic [DW-1:0] r2,
  output logic [1:0]    hit,
  output act_e          act,
  output logic [DW-1:0] b0,
  output logic [DW-1:0] b1
);
  always_comb begin
    hit[0] = ctrl.on1 && (ch == cmp1);
    hit[1] = ctrl.on2 && (ch == cmp2);
    act    = ACT_ONE;
    b0     = ch;
    b1     = r1hi;
    if (hit[0]) begin
      // drop outranks replace on compare 1
      if (ctrl.drop1)     act = ACT_DROP;
      else if (ctrl.dbl1) begin
        act = ACT_TWO;
        b0  = r1lo;
      end
    end else if (hit[1]) begin
      if (ctrl.drop2)     act = ACT_DROP;
      else if (ctrl.sub2) b0  = r2;
    end
  end
endmodule

// File: rtl/cf_outstage.sv
module cf_outstage
  import cf_pkg::*;
#(
  parameter int DW = CF_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  act_e          act,
  input  logic [DW-1:0] b0,
  input  logic [DW-1:0] b1,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          take,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  logic          ov_q, ov_d;
  logic          pend_q, pend_d;
  logic [DW-1:0] od_q, od_d;
  logic [DW-1:0] sec_q, sec_d;
  logic          pop;

  always_comb begin
    in_ready = !pend_q && (!ov_q || out_ready);
    take     = in_valid && in_ready;
    pop      = ov_q && out_ready;
    ov_d     = ov_q;
    od_d     = od_q;
    pend_d   = pend_q;
    sec_d    = sec_q;
    if (pop) begin
      ov_d = 1'b0;
      if (pend_q) begin
        ov_d   = 1'b1;
        od_d   = sec_q;
        pend_d = 1'b0;
      end
    end
    if (take && act != ACT_DROP) begin
      ov_d = 1'b1;
      od_d = b0;
      if (act == ACT_TWO) begin
        pend_d = 1'b1;
        sec_d  = b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q   <= 1'b0;
      pend_q <= 1'b0;
      od_q   <= '0;
      sec_q  <= '0;
    end else begin
      ov_q   <= ov_d;
      pend_q <= pend_d;
      od_q   <= od_d;
      sec_q  <= sec_d;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
endmodule

// File: rtl/cf_flags.sv
module cf_flags
  import cf_pkg::*;
#(
  parameter int N = CF_NCMP
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic         take,
  input  logic         clr,
  output logic [N-1:0] stb,
  output logic [N-1:0] flag
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic ev, stb_q, flag_q, flag_d;

    always_comb begin
      ev     = take && hit[g];
      flag_d = (flag_q && !clr) || ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stb_q  <= 1'b0;
        flag_q <= 1'b0;
      end else begin
        stb_q  <= ev;
        flag_q <= flag_d;
      end
    end

    assign stb[g]  = stb_q;
    assign flag[g] = flag_q;
  end
endmodule

// File: rtl/char_filter.sv
module char_filter
  import cf_pkg::*;
#(
  parameter int DW = CF_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  input  logic          cfg_we,
  input  logic [CF_AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          stat_rd,
  output logic [CF_NCMP-1:0] hit_stb,
  output logic [CF_NCMP-1:0] match_flag
);
  logic [DW-1:0] bank [CF_NREG];
  ctrl_t         ctrl;
  logic [1:0]    hit;
  act_e          act;
  logic [DW-1:0] b0, b1;
  logic          take;

  cf_cfg #(.DW(DW), .NREG(CF_NREG), .AW(CF_AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .bank(bank)
  );

  assign ctrl = ctrl_t'(bank[A_CTRL][$bits(ctrl_t)-1:0]);

  cf_decide #(.DW(DW)) u_dec (
    .ch(in_data), .ctrl(ctrl),
    .cmp1(bank[A_CMP1]), .cmp2(bank[A_CMP2]),
    .r1lo(bank[A_R1LO]), .r1hi(bank[A_R1HI]), .r2(bank[A_R2]),
    .hit(hit), .act(act), .b0(b0), .b1(b1)
  );

  cf_outstage #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .act(act),
    .b0(b0), .b1(b1), .out_ready(out_ready), .in_ready(in_ready),
    .take(take), .out_valid(out_valid), .out_data(out_data)
  );

  cf_flags #(.N(CF_NCMP)) u_flg (
    .clk(clk), .rst_n(rst_n), .hit(hit), .take(take), .clr(stat_rd),
    .stb(hit_stb), .flag(match_flag)
  );
endmodule

// File: rtl/char_filter_chk.sv
module char_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_ready,
  input logic       stat_rd,
  input logic [1:0] hit_stb,
  input logic [1:0] match_flag
);
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && match_flag == 2'b00));

  p_hold_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_block_in_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_stb_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_stb[0] |-> match_flag[0]) and (hit_stb[1] |-> match_flag[1]));

  p_stb_after_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_stb != 2'b00) |-> $past(in_valid && in_ready));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag[0] && !stat_rd) |=> match_flag[0]);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (match_flag == hit_stb));
endmodule

bind char_filter char_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
  .stat_rd(stat_rd), .hit_stb(hit_stb), .match_flag(match_flag)
);

// File: tb/char_filter_bench.sv
module char_filter_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, out_valid, out_ready;
  logic [7:0] in_data, out_data, cfg_wdata;
  logic       cfg_we, stat_rd;
  logic [2:0] cfg_addr;
  logic [1:0] hit_stb, match_flag;

  int total = 0;
  int bad   = 0;
  logic [7:0] rx [64];
  int nrx = 0;
  logic [7:0] ex [64];
  int nex = 0;
  bit done = 0;

  char_filter u_char_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .stat_rd(stat_rd), .hit_stb(hit_stb),
    .match_flag(match_flag)
  );

  always #4 clk = ~clk;

  // record each output transfer, sampled between edges
  always @(negedge clk) begin
    #2;
    if (rst_n === 1'b1 && out_valid && out_ready && nrx < 64) begin
      rx[nrx] = out_data;
      nrx++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clr_flags();
    @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  // returns at the falling edge right after the accepting edge
  task automatic send(input logic [7:0] d);
    bit acc;
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    acc = 1'b0;
    while (!acc) begin
      #2;
      acc = in_ready;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic expect_b(input logic [7:0] d);
    ex[nex] = d;
    nex++;
  endtask

  task automatic start();
    nrx = 0;
    nex = 0;
  endtask

  task automatic finish_stream(input string req);
    repeat (6) @(negedge clk);
    chk(nrx == nex, {req, " count"}, nrx, nex);
    for (int i = 0; i < nex && i < nrx; i++)
      chk(rx[i] == ex[i], {req, " byte"}, rx[i], ex[i]);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(match_flag == 2'b00, "R1 flags", match_flag, 0);
    chk(hit_stb == 2'b00, "R1 strobes", hit_stb, 0);
  endtask

  task automatic t_pass();
    wr(3'd0, 8'h00); wr(3'd1, 8'h41); wr(3'd2, 8'h42);
    clr_flags();
    start();
    send(8'h41); expect_b(8'h41);
    chk(hit_stb == 2'b00, "R12 no strobe", hit_stb, 0);
    send(8'h10); expect_b(8'h10);
    send(8'hFF); expect_b(8'hFF);
    send(8'h42); expect_b(8'h42);
    finish_stream("R2");
    chk(match_flag == 2'b00, "R12 no flag", match_flag, 0);
  endtask

  task automatic t_drop1();
    wr(3'd0, 8'h05); wr(3'd1, 8'h41);
    clr_flags();
    start();
    send(8'h30); expect_b(8'h30);
    send(8'h41);
    chk(hit_stb == 2'b01, "R9 strobe on", hit_stb, 1);
    chk(match_flag == 2'b01, "R8 flag set", match_flag, 1);
    @(negedge clk);
    chk(hit_stb == 2'b00, "R9 strobe one cycle", hit_stb, 0);
    send(8'h31); expect_b(8'h31);
    finish_stream("R3");
  endtask

  task automatic t_rep1();
    wr(3'd0, 8'h11); wr(3'd1, 8'h41); wr(3'd3, 8'hA1); wr(3'd4, 8'hB2);
    clr_flags();
    start();
    send(8'h20); expect_b(8'h20);
    send(8'h41); expect_b(8'hA1); expect_b(8'hB2);
    chk(in_ready == 1'b0, "R4 stall", in_ready, 0);
    send(8'h21); expect_b(8'h21);
    finish_stream("R4");
  endtask

  task automatic t_prio();
    wr(3'd0, 8'h15);
    start();
    send(8'h41);
    send(8'h22); expect_b(8'h22);
    finish_stream("R5");
  endtask

  task automatic t_cmp2();
    wr(3'd0, 8'h0A); wr(3'd2, 8'h0D); wr(3'd5, 8'h7E);
    clr_flags();
    start();
    send(8'h0D);
    chk(hit_stb == 2'b10, "R6 strobe2", hit_stb, 2);
    send(8'h01); expect_b(8'h01);
    finish_stream("R6 drop");
    wr(3'd0, 8'h22);
    start();
    send(8'h0D); expect_b(8'h7E);
    send(8'h02); expect_b(8'h02);
    finish_stream("R6 replace");
  endtask

  task automatic t_matchonly();
    wr(3'd0, 8'h03); wr(3'd1, 8'h61); wr(3'd2, 8'h62);
    clr_flags();
    start();
    send(8'h61); expect_b(8'h61);
    send(8'h62); expect_b(8'h62);
    finish_stream("R7");
    chk(match_flag == 2'b11, "R7 flags", match_flag, 3);
  endtask

  task automatic t_sticky();
    repeat (5) @(negedge clk);
    chk(match_flag == 2'b11, "R8 hold", match_flag, 3);
    clr_flags();
    chk(match_flag == 2'b00, "R8 cleared", match_flag, 0);
    start();
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h61; stat_rd = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; stat_rd = 1'b0;
    chk(match_flag == 2'b01, "R8 set wins", match_flag, 1);
    expect_b(8'h61);
    finish_stream("R8 stream");
  endtask

  task automatic t_both();
    wr(3'd0, 8'h13); wr(3'd1, 8'h5A); wr(3'd2, 8'h5A);
    wr(3'd3, 8'hC3); wr(3'd4, 8'hD4);
    clr_flags();
    start();
    send(8'h5A); expect_b(8'hC3); expect_b(8'hD4);
    chk(hit_stb == 2'b11, "R10 strobes", hit_stb, 3);
    finish_stream("R10");
    chk(match_flag == 2'b11, "R10 flags", match_flag, 3);
  endtask

  task automatic t_bp();
    wr(3'd0, 8'h11); wr(3'd1, 8'h41); wr(3'd3, 8'hA1); wr(3'd4, 8'hB2);
    start();
    @(negedge clk);
    out_ready = 1'b0;
    send(8'h41); expect_b(8'hA1); expect_b(8'hB2);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b1, "R11 valid held", out_valid, 1);
    chk(out_data == 8'hA1, "R11 data held", out_data, 8'hA1);
    chk(in_ready == 1'b0, "R11 in blocked", in_ready, 0);
    out_ready = 1'b1;
    send(8'h33); expect_b(8'h33);
    finish_stream("R11");
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; stat_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pass();
    t_drop1();
    t_rep1();
    t_prio();
    t_cmp2();
    t_matchonly();
    t_sticky();
    t_both();
    t_bp();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule